// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block produces the word addresses for a synchronous burst read from a 16-bit-wide memory array. A host pulls the active-low address-valid strobe while presenting a start address. The sequencer then counts out a programmable number of initial wait states, raises ready together with the first word address, and from then on steps the address on every active clock edge. The stepping follows either a wrapping burst of 8, 16 or 32 words inside an aligned group, or an unbounded sequential count.

A small configuration register, written on the rising edge of the base clock, holds the burst mode, the active-edge choice, the wait-state count and a reduced-latency option. The reduced-latency option shortens the initial wait by one cycle for bursts that begin on an even word. A suspend input freezes the burst and keeps its position, so the array bus can be used for other traffic and the burst picked up again later. Loading a new start address at any time abandons the burst in flight.

Top module: `burst_addr_seq`

## Requirements
- R1: When avdN is low at an active edge, addr takes startAddr at that edge and ready is low after it.
- R2: cfgMode 2'b01, 2'b10 and 2'b11 select wrapping bursts of 8, 16 and 32 words. Each step increments only the low 3, 4 or 5 address bits modulo the length, and the bits above them stay fixed.
- R3: cfgMode 2'b00 selects continuous mode, where each step adds one to the full address with no wrap at any group boundary.
- R4: With the reduced option not in effect, ready first goes high on the (cfgWait+2)-th active edge after the load edge, with addr still equal to the start address.
- R5: Ready stays low through the wait states. Once high, it stays high, and addr advances by one step at every active edge while suspend is low and avdN is high.
- R6: With cfgReduced=1 and startAddr[0]=0, ready first goes high on the (cfgWait+1)-th active edge after the load edge. An odd start keeps the R4 latency.
- R7: During a burst, an active edge with suspend high holds addr and drives ready low. The first active edge with suspend low again moves addr to the next address in sequence and raises ready. Suspend has no effect during wait states.
- R8: cfgFalling=1 makes the sequencer act on the falling edges of clk, and cfgFalling=0 makes it act on the rising edges.
- R9: cfgWrite high at a rising clk edge latches cfgModeIn, cfgFallingIn, cfgWaitIn and cfgReducedIn. Reset gives continuous mode, rising edge, zero wait, reduced off, addr 0 and ready low.
- R10: A load during a running burst cancels it: the new start address appears at once and the wait-state count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; the configuration register uses its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| avdN | input | 1 | Address-valid strobe, active low; loads the start address |
| startAddr | input | ADDR_W | First word address of the burst |
| suspend | input | 1 | High holds the burst at its current position |
| cfgWrite | input | 1 | Latches the configuration inputs |
| cfgModeIn | input | 2 | 00 continuous, 01 wrap 8, 10 wrap 16, 11 wrap 32 |
| cfgFallingIn | input | 1 | 1 selects the falling edge as active edge |
| cfgWaitIn | input | WAIT_W | Base initial wait-state count |
| cfgReducedIn | input | 1 | Enables one fewer wait state for even starts |
| addr | output | ADDR_W | Current array word address |
| ready | output | 1 | High while the word at addr may be sampled |

## Verification
The wrapping modes are started at offsets just below their group boundary and with nonzero upper bits. Each sequence must fold back within its own group, and this separates the three mask widths from one another and from the continuous count. The continuous burst is run across an 8-word and a 1K boundary, which exposes any wrong wrap. Latency is measured at the smallest and largest wait counts and with even and odd starts under the reduced option, so an off-by-one error in either direction shows. Suspend, restart during a burst and falling-edge operation are each checked on the edge where the address should change and on the edge where it should not.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    MODE_CONT   = 2'b00,
    MODE_WRAP8  = 2'b01,
    MODE_WRAP16 = 2'b10,
    MODE_WRAP32 = 2'b11
  } burstMode_e;

  typedef struct packed {
    logic load;
    logic advance;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_WAIT  = 2'b01,
    ST_BURST = 2'b10
  } seqState_e;

endpackage

// File: rtl/bseq_cfg.sv
module bseq_cfg
  import bseq_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [1:0]        cfgModeIn,
  input  logic              cfgFallingIn,
  input  logic [WAIT_W-1:0] cfgWaitIn,
  input  logic              cfgReducedIn,
  output burstMode_e        cfgMode,
  output logic              cfgFalling,
  output logic [WAIT_W-1:0] cfgWait,
  output logic              cfgReduced
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgMode    <= MODE_CONT;
      cfgFalling <= 1'b0;
      cfgWait    <= '0;
      cfgReduced <= 1'b0;
    end else if (cfgWrite) begin
      cfgMode    <= burstMode_e'(cfgModeIn);
      cfgFalling <= cfgFallingIn;
      cfgWait    <= cfgWaitIn;
      cfgReduced <= cfgReducedIn;
    end
  end

endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              activeClk,
  input  logic              rstN,
  input  logic              avdN,
  input  logic              startEven,
  input  logic              suspend,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              cfgReduced,
  output seqStrobe_t        stb,
  output logic              ready
);

  localparam int CNT_W = WAIT_W + 1;

  seqState_e        stateQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntLoad;
  logic             shortStart;

  assign shortStart = cfgReduced && startEven;
  assign cntLoad    = {1'b0, cfgWait} + (shortStart ? CNT_W'(0) : CNT_W'(1));

  always_comb begin
    stb.load    = !avdN;
    stb.advance = avdN && (stateQ == ST_BURST) && !suspend;
  end

  always_ff @(posedge activeClk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      ready  <= 1'b0;
    end else if (!avdN) begin
      stateQ <= ST_WAIT;
      cntQ   <= cntLoad;
      ready  <= 1'b0;
    end else begin
      unique case (stateQ)
        ST_WAIT: begin
          if (cntQ == '0) begin
            stateQ <= ST_BURST;
            ready  <= 1'b1;
          end else begin
            cntQ <= cntQ - CNT_W'(1);
          end
        end
        ST_BURST: ready <= !suspend;
        default: ready <= 1'b0;
      endcase
    end
  end

  AST_LOAD_DROPS_READY: assert property (@(posedge activeClk) disable iff (!rstN)
    !avdN |=> !ready); // R1

  AST_READY_HOLDS: assert property (@(posedge activeClk) disable iff (!rstN)
    (ready && avdN && !suspend) |=> ready); // R5

endmodule

// File: rtl/bseq_datapath.sv
module bseq_datapath
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 23
) (
  input  logic              activeClk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  burstMode_e        cfgMode,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] incAddr;
  logic [ADDR_W-1:0] lowMask;
  logic [ADDR_W-1:0] nextAddr;
  logic              wrapOn;

  assign incAddr = addr + ADDR_W'(1);
  assign wrapOn  = (cfgMode != MODE_CONT);

  always_comb begin
    unique case (cfgMode)
      MODE_WRAP8:  lowMask = ADDR_W'(7);
      MODE_WRAP16: lowMask = ADDR_W'(15);
      MODE_WRAP32: lowMask = ADDR_W'(31);
      default:     lowMask = '1;
    endcase
    nextAddr = (addr & ~lowMask) | (incAddr & lowMask);
  end

  always_ff @(posedge activeClk or negedge rstN) begin
    if (!rstN)            addr <= '0;
    else if (stb.load)    addr <= startAddr;
    else if (stb.advance) addr <= nextAddr;
  end

  AST_LOAD_TAKES_START: assert property (@(posedge activeClk) disable iff (!rstN)
    stb.load |=> (addr == $past(startAddr))); // R1

  AST_WRAP_UPPER_FIXED: assert property (@(posedge activeClk) disable iff (!rstN)
    (stb.advance && !stb.load && wrapOn) |=>
      ((addr & ~$past(lowMask)) == ($past(addr) & ~$past(lowMask)))); // R2

  AST_CONT_STEP: assert property (@(posedge activeClk) disable iff (!rstN)
    (stb.advance && !stb.load && !wrapOn) |=> (addr == $past(addr) + ADDR_W'(1))); // R3

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              avdN,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              suspend,
  input  logic              cfgWrite,
  input  logic [1:0]        cfgModeIn,
  input  logic              cfgFallingIn,
  input  logic [WAIT_W-1:0] cfgWaitIn,
  input  logic              cfgReducedIn,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);

  burstMode_e        cfgMode;
  logic              cfgFalling;
  logic [WAIT_W-1:0] cfgWait;
  logic              cfgReduced;
  logic              activeClk;
  seqStrobe_t        stb;

  assign activeClk = clk ^ cfgFalling;

  bseq_cfg #(.WAIT_W(WAIT_W)) u_cfg (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite),
    .cfgModeIn(cfgModeIn), .cfgFallingIn(cfgFallingIn),
    .cfgWaitIn(cfgWaitIn), .cfgReducedIn(cfgReducedIn),
    .cfgMode(cfgMode), .cfgFalling(cfgFalling),
    .cfgWait(cfgWait), .cfgReduced(cfgReduced)
  );

  bseq_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .activeClk(activeClk), .rstN(rstN), .avdN(avdN),
    .startEven(!startAddr[0]), .suspend(suspend),
    .cfgWait(cfgWait), .cfgReduced(cfgReduced),
    .stb(stb), .ready(ready)
  );

  bseq_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .activeClk(activeClk), .rstN(rstN), .stb(stb),
    .cfgMode(cfgMode), .startAddr(startAddr), .addr(addr)
  );

  AST_SUSPEND_FREEZES: assert property (@(posedge activeClk) disable iff (!rstN)
    (avdN && suspend && ready) |=> (!ready && addr == $past(addr))); // R7

endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;

  localparam int AW = 23;
  localparam int WW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          avdN = 1'b1;
  logic [AW-1:0] startAddr = '0;
  logic          suspend = 1'b0;
  logic          cfgWrite = 1'b0;
  logic [1:0]    cfgModeIn = 2'b00;
  logic          cfgFallingIn = 1'b0;
  logic [WW-1:0] cfgWaitIn = '0;
  logic          cfgReducedIn = 1'b0;
  logic [AW-1:0] addr;
  logic          ready;

  int  nChecks = 0;
  int  nFails = 0;
  logic fallMode = 1'b0;

  burst_addr_seq #(.ADDR_W(AW), .WAIT_W(WW)) dut (
    .clk(clk), .rstN(rstN), .avdN(avdN), .startAddr(startAddr),
    .suspend(suspend), .cfgWrite(cfgWrite), .cfgModeIn(cfgModeIn),
    .cfgFallingIn(cfgFallingIn), .cfgWaitIn(cfgWaitIn),
    .cfgReducedIn(cfgReducedIn), .addr(addr), .ready(ready)
  );

  always #5 clk = ~clk;

  function automatic logic [AW-1:0] nextA(input logic [AW-1:0] a, input logic [1:0] mode);
    logic [AW-1:0] m;
    if (mode == 2'b00) return a + AW'(1);
    m = (AW'(1) << (int'(mode) + 2)) - AW'(1);
    return (a & ~m) | ((a + AW'(1)) & m);
  endfunction

  task automatic tick();
    if (fallMode) @(negedge clk);
    else          @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [AW-1:0] expA, input logic expR);
    nChecks++;
    if (addr !== expA || ready !== expR) begin
      nFails++;
      $display("FAIL %s: addr=%h ready=%b expected addr=%h ready=%b",
               req, addr, ready, expA, expR);
    end
  endtask

  task automatic setCfg(input logic [1:0] mode, input logic fall,
                        input logic [WW-1:0] w, input logic red);
    cfgModeIn = mode; cfgFallingIn = fall; cfgWaitIn = w; cfgReducedIn = red;
    cfgWrite = 1'b1;
    @(posedge clk); #1;
    cfgWrite = 1'b0;
    fallMode = fall;
    tick();
  endtask

  // Loads start, checks latency and the address sequence for nWords words.
  task automatic runBurst(input logic [AW-1:0] s, input logic [1:0] mode,
                          input int w, input logic red, input int nWords,
                          input string latTag, input string seqTag);
    logic [AW-1:0] a;
    int lat;
    lat = w + 2 - ((red && !s[0]) ? 1 : 0);
    avdN = 1'b0; startAddr = s;
    tick();
    avdN = 1'b1;
    chk("R1 load", s, 1'b0);
    for (int k = 1; k < lat; k++) begin
      tick();
      chk("R5 wait low", s, 1'b0);
    end
    tick();
    chk(latTag, s, 1'b1);
    a = s;
    for (int j = 1; j < nWords; j++) begin
      tick();
      a = nextA(a, mode);
      chk(seqTag, a, 1'b1);
    end
  endtask

  task automatic testReset();
    chk("R9 reset state", '0, 1'b0);
    runBurst(AW'(6), 2'b00, 0, 1'b0, 4, "R9 default latency", "R9 default continuous");
  endtask

  task automatic testWraps();
    setCfg(2'b01, 1'b0, 3'd1, 1'b0);
    runBurst(AW'('h105), 2'b01, 1, 1'b0, 6, "R4 lat wrap8", "R2 wrap8");
    setCfg(2'b10, 1'b0, 3'd0, 1'b0);
    runBurst(AW'('h21E), 2'b10, 0, 1'b0, 5, "R4 lat wrap16", "R2 wrap16");
    setCfg(2'b11, 1'b0, 3'd2, 1'b0);
    runBurst(AW'('h7ABFD), 2'b11, 2, 1'b0, 5, "R4 lat wrap32", "R2 wrap32");
  endtask

  task automatic testContinuous();
    setCfg(2'b00, 1'b0, 3'd7, 1'b0);
    runBurst(AW'('h3FE), 2'b00, 7, 1'b0, 5, "R4 lat max wait", "R3 continuous");
  endtask

  task automatic testReduced();
    setCfg(2'b00, 1'b0, 3'd3, 1'b1);
    runBurst(AW'('h40), 2'b00, 3, 1'b1, 2, "R6 even start shorter", "R6 seq");
    runBurst(AW'('h41), 2'b00, 3, 1'b1, 2, "R6 odd start full", "R6 seq");
  endtask

  task automatic testSuspend();
    setCfg(2'b01, 1'b0, 3'd0, 1'b0);
    runBurst(AW'('h13), 2'b01, 0, 1'b0, 3, "R4 lat", "R2 seq");
    suspend = 1'b1;
    tick(); chk("R7 suspend hold", AW'('h15), 1'b0);
    tick(); chk("R7 suspend hold 2", AW'('h15), 1'b0);
    suspend = 1'b0;
    tick(); chk("R7 resume next", AW'('h16), 1'b1);
    tick(); chk("R7 resume seq", AW'('h17), 1'b1);
    tick(); chk("R7 resume wrap", AW'('h10), 1'b1);
  endtask

  task automatic testRestart();
    setCfg(2'b00, 1'b0, 3'd0, 1'b0);
    runBurst(AW'('h500), 2'b00, 0, 1'b0, 3, "R4 lat", "R3 seq");
    avdN = 1'b0; startAddr = AW'('h900);
    tick(); avdN = 1'b1;
    chk("R10 restart load", AW'('h900), 1'b0);
    tick(); chk("R10 wait restarted", AW'('h900), 1'b0);
    tick(); chk("R10 ready after restart", AW'('h900), 1'b1);
    tick(); chk("R10 seq after restart", AW'('h901), 1'b1);
  endtask

  task automatic testFalling();
    setCfg(2'b00, 1'b1, 3'd0, 1'b0);
    runBurst(AW'('h77), 2'b00, 0, 1'b0, 2, "R8 lat falling", "R8 seq falling");
    @(posedge clk); #2;
    chk("R8 no change on rising", AW'('h78), 1'b1);
    tick();
    chk("R8 change on falling", AW'('h79), 1'b1);
    setCfg(2'b00, 1'b0, 3'd0, 1'b0);
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #23 rstN = 1'b1;
    #1;
    testReset();
    testWraps();
    testContinuous();
    testReduced();
    testSuspend();
    testRestart();
    testFalling();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule